// File: doc/BRIEF.md
# Single-Block Message Padder

The block collects a short message one byte at a time from a serial-style receiver and lays it into a 64-byte buffer. Each byte goes into the next free position. It waits for an explicit end-of-message strobe before it changes anything else. When the strobe arrives, it rewrites the buffer in place as one complete 512-bit hash input block. That block holds the message, then a single marker byte, then zero fill, then the message length in bits.

A completion flag then starts the downstream message-schedule and compression stages. The padded block is available in two forms: as one 512-bit vector, and as sixteen 32-bit words picked by an index. A message too long for a single block raises an error flag instead of the completion flag. A clear pulse, or the synchronous reset, prepares the block for the next message.

Top module: `msg_block_padder`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the buffer empties to all zero bytes, the byte count returns to zero, and both `done_o` and `err_o` go low.
- R2: Accepted message bytes are stored in arrival order from byte 0 upward. Byte b of the buffer appears at `block_o[511-8b -: 8]`, so the first byte is the most significant.
- R3: Before the end strobe is sampled, no padding is applied: `block_o` shows only the received bytes with zeros elsewhere, and `done_o` stays low.
- R4: After padding, the byte directly after the last message byte is 0x80, and every later byte up to byte 55 is 0x00.
- R5: Bytes 56 to 63 hold the message length in bits (byte count times 8) as a 64-bit big-endian value, with byte 63 least significant.
- R6: `done_o` is low after the edge that samples `msg_end_i` and high after the next edge. It then stays high until a clear pulse or a reset.
- R7: A byte presented with `msg_end_i` in the same cycle is part of the message.
- R8: A message of more than 55 bytes sets `err_o` on the second edge after the end strobe. `done_o` is never raised for it, and `err_o` holds until a clear pulse or a reset.
- R9: While `done_o` or `err_o` is high, further bytes and end strobes leave the block unchanged.
- R10: A clear pulse has the same effect as R1. When a byte arrives in the same cycle as the clear, the clear wins and the byte is dropped.
- R11: `word_o` equals block word `word_sel_i`, built from bytes 4i to 4i+3 with byte 4i in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Start-of-message pulse; empties the buffer and drops both flags |
| byte_vld_i | input | 1 | A message byte is present |
| byte_i | input | 8 | Message byte |
| msg_end_i | input | 1 | End-of-message strobe |
| word_sel_i | input | 4 | Index of the word shown on `word_o` |
| block_o | output | 512 | Buffer contents; the padded block once `done_o` is high |
| word_o | output | 32 | Selected 32-bit block word |
| done_o | output | 1 | Padded block ready |
| err_o | output | 1 | Message too long for one block |

## Verification
Two pairs of functions can land in the same cycle: capture of the final byte and the end strobe, and a byte capture and a clear pulse. The vector table marks some messages to carry the end strobe on their last byte. For those, the padded block must still place 0x80 and the length after that byte. A directed step drives a byte and a clear together. It then checks that the buffer reads all zero and that the next message starts at byte 0 with the new byte and no trace of the dropped one.

// File: rtl/msg_block_padder.sv
module msg_block_padder #(
  parameter int BLK_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   byte_vld_i,
  input  logic [7:0]             byte_i,
  input  logic                   msg_end_i,
  input  logic [3:0]             word_sel_i,
  output logic [BLK_BYTES*8-1:0] block_o,
  output logic [31:0]            word_o,
  output logic                   done_o,
  output logic                   err_o
);
  localparam int LEN_BYTES = 8;
  localparam int DATA_MAX  = BLK_BYTES - LEN_BYTES - 1;
  localparam int CNT_W     = $clog2(BLK_BYTES) + 1;
  localparam int WORDS     = BLK_BYTES / 4;

  typedef enum logic [1:0] {S_CAP, S_PAD, S_HOLD} st_t;

  st_t              st_q;
  logic [7:0]       buf_q [BLK_BYTES];
  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  logic [63:0]      bit_len;

  assign bit_len = 64'(cnt_q) << 3;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      for (int i = 0; i < BLK_BYTES; i++) buf_q[i] <= 8'h00;
      cnt_q  <= '0;
      long_q <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      st_q   <= S_CAP;
    end else begin
      case (st_q)
        S_CAP: begin
          if (byte_vld_i) begin
            if (cnt_q < CNT_W'(DATA_MAX)) begin
              buf_q[cnt_q[CNT_W-2:0]] <= byte_i;
              cnt_q <= cnt_q + 1'b1;
            end else begin
              long_q <= 1'b1;
            end
          end
          if (msg_end_i) st_q <= S_PAD;
        end
        S_PAD: begin
          if (long_q) begin
            err_o <= 1'b1;
          end else begin
            for (int i = 0; i < BLK_BYTES; i++) begin
              if (CNT_W'(i) == cnt_q)
                buf_q[i] <= 8'h80;
              else if (CNT_W'(i) > cnt_q && i < BLK_BYTES - LEN_BYTES)
                buf_q[i] <= 8'h00;
              else if (i >= BLK_BYTES - LEN_BYTES)
                buf_q[i] <= bit_len[8*(BLK_BYTES-1-i) +: 8];
            end
            done_o <= 1'b1;
          end
          st_q <= S_HOLD;
        end
        default: st_q <= S_HOLD;
      endcase
    end
  end

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_pack
    assign block_o[8*(BLK_BYTES-1-b) +: 8] = buf_q[b];
  end

  assign word_o = block_o[32*(WORDS-1-int'(word_sel_i)) +: 32];

  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !clear_i |=> done_o);

  // R6
  done_after_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(st_q == S_PAD));

  // R9
  block_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) && !clear_i |=> $stable(block_o));

  // R10
  clear_drops_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !done_o && !err_o && cnt_q == '0);

  // R3
  no_done_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_CAP |-> !done_o && !err_o);
endmodule

// File: tb/msg_block_padder_tb.sv
`timescale 1ns/1ps
module msg_block_padder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear_i = 1'b0, byte_vld_i = 1'b0, msg_end_i = 1'b0;
  logic [7:0]   byte_i = 8'h00;
  logic [3:0]   word_sel_i = 4'd0;
  logic [511:0] block_o;
  logic [31:0]  word_o;
  logic         done_o, err_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  msg_block_padder dut_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .msg_end_i(msg_end_i), .word_sel_i(word_sel_i),
    .block_o(block_o), .word_o(word_o), .done_o(done_o), .err_o(err_o)
  );

  // {together, len[6:0], seed[7:0]}
  localparam logic [15:0] VEC [7] = '{
    {1'b0, 7'd0,  8'h00}, {1'b1, 7'd1,  8'hA5}, {1'b0, 7'd3,  8'h61},
    {1'b1, 7'd4,  8'h10}, {1'b0, 7'd31, 8'h3C}, {1'b1, 7'd54, 8'hF0},
    {1'b0, 7'd55, 8'h07}
  };

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 37);
  endfunction

  function automatic logic [511:0] expect_blk(input int len, input logic [7:0] seed,
                                              input bit padded);
    logic [511:0] r = '0;
    logic [63:0]  bl = 64'(len) * 64'd8;
    for (int b = 0; b < 64; b++) begin
      logic [7:0] v = 8'h00;
      if (b < len) v = pat(seed, b);
      else if (padded && b == len) v = 8'h80;
      else if (padded && b >= 56) v = bl[8*(63-b) +: 8];
      r[8*(63-b) +: 8] = v;
    end
    return r;
  endfunction

  task automatic drv(input logic v, input logic [7:0] b, input logic e, input logic c);
    @(negedge clk);
    byte_vld_i = v; byte_i = b; msg_end_i = e; clear_i = c;
  endtask

  task automatic idle();
    drv(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic chk_blk(input string req, input logic [511:0] exp);
    checks++;
    if (block_o !== exp) begin
      fails++;
      $display("FAIL %s block act=%h exp=%h", req, block_o, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b", req, nm, act, exp);
    end
  endtask

  task automatic chk_word(input logic [3:0] sel, input logic [511:0] blk);
    word_sel_i = sel;
    #0.1;
    checks++;
    if (word_o !== blk[32*(15-int'(sel)) +: 32]) begin
      fails++;
      $display("FAIL R11 word%0d act=%h exp=%h", sel, word_o, blk[32*(15-int'(sel)) +: 32]);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [511:0] e;
    repeat (3) idle();
    rst_n = 1'b1;
    idle();
    // R1 reset state
    chk_blk("R1", '0);
    chk_bit("R1", "done", done_o, 1'b0);
    chk_bit("R1", "err", err_o, 1'b0);

    for (int n = 0; n < 7; n++) begin
      automatic bit         tog  = VEC[n][15];
      automatic int         len  = int'(VEC[n][14:8]);
      automatic logic [7:0] seed = VEC[n][7:0];
      drv(1'b0, 8'h00, 1'b0, 1'b1);
      for (int k = 0; k < len; k++)
        drv(1'b1, pat(seed, k), tog && (k == len - 1), 1'b0);
      if (!tog || len == 0) begin
        idle();
        // R3 no padding before strobe; R2 byte order
        chk_blk("R3/R2", expect_blk(len, seed, 1'b0));
        chk_bit("R3", "done", done_o, 1'b0);
        drv(1'b0, 8'h00, 1'b1, 1'b0);
      end
      idle();
      // R6 done low after the strobe edge
      chk_bit("R6", "done", done_o, 1'b0);
      idle();
      chk_bit("R6", "done", done_o, 1'b1);
      e = expect_blk(len, seed, 1'b1);
      // R4 R5 R7 padded block
      chk_blk(tog ? "R7/R4/R5" : "R4/R5", e);
      chk_word(4'd0, e);
      chk_word(4'(len / 4), e);
      chk_word(4'd15, e);
      idle();
      chk_bit("R6", "done held", done_o, 1'b1);
    end

    // R9 bytes and strobe ignored after done (55-byte vector still held)
    e = expect_blk(55, 8'h07, 1'b1);
    drv(1'b1, 8'hAA, 1'b0, 1'b0);
    drv(1'b1, 8'hBB, 1'b1, 1'b0);
    idle(); idle();
    chk_blk("R9", e);
    chk_bit("R9", "done", done_o, 1'b1);

    // R8 too-long message
    drv(1'b0, 8'h00, 1'b0, 1'b1);
    for (int k = 0; k < 56; k++) drv(1'b1, pat(8'h5A, k), 1'b0, 1'b0);
    drv(1'b0, 8'h00, 1'b1, 1'b0);
    idle();
    chk_bit("R8", "err early", err_o, 1'b0);
    idle();
    chk_bit("R8", "err", err_o, 1'b1);
    chk_bit("R8", "done", done_o, 1'b0);
    drv(1'b1, 8'h01, 1'b1, 1'b0);
    idle(); idle();
    chk_bit("R8", "err held", err_o, 1'b1);
    chk_bit("R8", "done stays low", done_o, 1'b0);
    chk_blk("R9", expect_blk(55, 8'h5A, 1'b0));

    // R10 clear beats a byte in the same cycle
    drv(1'b1, 8'hEE, 1'b0, 1'b1);
    idle();
    chk_blk("R10", '0);
    chk_bit("R10", "err", err_o, 1'b0);
    drv(1'b1, pat(8'h11, 0), 1'b1, 1'b0);
    idle(); idle();
    chk_blk("R10", expect_blk(1, 8'h11, 1'b1));

    // R1 reset mid-operation
    rst_n = 1'b0;
    idle();
    rst_n = 1'b1;
    idle();
    chk_blk("R1", '0);
    chk_bit("R1", "done", done_o, 1'b0);

    summary();
  end
endmodule